// File: doc/BRIEF.md
# PHY Error Statistics Counter Bank

This block keeps four 16-bit error statistics for a fast Ethernet PHY and serves them to a management register read port. It tracks receive symbol errors, premature end-of-frame events on the 100 Mb/s receive path, end-of-frame errors on the 10 Mb/s receive path, and jabber events on the 10 Mb/s transmit path. The line decoders supply single-cycle event strobes for the last three. For symbol errors they supply a per-symbol valid flag, a bad flag and a frame-active level.

Each counter stops at full scale instead of wrapping, and is cleared by the act of reading it. Bad symbols are not counted one by one. Inside a frame, each group of six consecutive bad symbols adds a single count. A good symbol or the end of the frame restarts the grouping.

Reads are made with a one-cycle strobe and an address. The value appears on the registered read data output one cycle later.

Top module: `phy_errstat_bank`

## Requirements
- R1: Register address 22 holds the symbol error count, 23 the 100 Mb/s premature end-of-frame count, 24 the 10 Mb/s end-of-frame error count and 25 the jabber count. Each strobe adds exactly one to its own counter only.
- R2: A counter at 0xFFFF stays at 0xFFFF when further events arrive.
- R3: A read of addresses 22 to 25 returns the counter's value and leaves that counter at zero.
- R4: Within a frame, a valid bad symbol adds one to the symbol error count when it is the first of a group of six consecutive bad symbols. A run of n bad symbols therefore adds ceil(n/6).
- R5: The grouping restarts on a valid good symbol and whenever the frame-active signal is low. Symbols presented with the valid flag low, or while frame-active is low, count nothing.
- R6: When an event and a read of the same counter fall in the same cycle, the read returns the old value and the counter is left at 1.
- R7: Address 26 and every other address outside 22 to 25 read as zero and change no counter.
- R8: While the synchronous active-low reset is asserted, all counters, the grouping state and the read data are cleared to zero.
- R9: Read data is updated in the cycle after the read strobe and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_valid | input | 1 | A received symbol is present this cycle |
| sym_bad | input | 1 | The present symbol failed decoding |
| frame_active | input | 1 | A receive frame is in progress |
| ev_premature_eof | input | 1 | 100 Mb/s premature end-of-frame strobe |
| ev_eof_err | input | 1 | 10 Mb/s end-of-frame error strobe |
| ev_jabber | input | 1 | 10 Mb/s transmit jabber strobe |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 5 | Register address for the read |
| rd_data | output | 16 | Registered read data |

## Verification
The symbol grouping is tried with several patterns:
- Runs of exactly five, six, seven, twelve and thirteen bad symbols, which separate a per-symbol count from a per-group count and expose an off-by-one in the group length.
- Runs split by a good symbol, by a frame drop, or by symbols whose valid flag is low, which separate a true restart from a mere pause.
- Bad symbols outside a frame, which show that the frame gate is applied.

The plain strobe counters are tried with distinct counts on each channel, to catch address swaps. They are also tried with a strobe coinciding with a read, to catch a lost event. Finally, a counter is driven past full scale and reads of reserved and unmapped addresses are made between loads and the read-back, to show that those reads leave the counters intact.

// File: rtl/phy_errstat_pkg.sv
// Shared constants for the PHY error statistics bank.
// Assumes the four counters occupy consecutive register addresses.
package phy_errstat_pkg;

    localparam int NUM_CNT  = 4;
    localparam int REG_BASE = 22;

    // Counter slot order; slot k answers at REG_BASE + k.
    typedef enum logic [1:0] {
        SLOT_SYMBOL    = 2'd0,
        SLOT_PREMATURE = 2'd1,
        SLOT_EOF_ERR   = 2'd2,
        SLOT_JABBER    = 2'd3
    } stat_slot_e;

endpackage

// File: rtl/sym_run_grouper.sv
// Turns a stream of per-symbol good/bad flags into one error event per
// group of GROUP_LEN consecutive bad symbols inside a frame.
// Assumes frame_active is a level that is low between frames.
module sym_run_grouper #(
    parameter int GROUP_LEN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sym_valid,
    input  logic sym_bad,
    input  logic frame_active,
    output logic grp_evt
);
    localparam int RUN_W = (GROUP_LEN < 2) ? 1 : $clog2(GROUP_LEN);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(GROUP_LEN - 1);

    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_d;
    logic             bad_here;

    // A bad symbol that counts toward a group.
    assign bad_here = frame_active && sym_valid && sym_bad;

    // The first bad symbol of each group raises the event.
    assign grp_evt = bad_here && (run_q == '0);

    // Next position within the current group of bad symbols.
    always_comb begin
        run_d = run_q;
        if (!frame_active) begin
            run_d = '0;
        end else if (sym_valid) begin
            if (!sym_bad) begin
                run_d = '0;
            end else if (run_q == RUN_LAST) begin
                run_d = '0;
            end else begin
                run_d = run_q + RUN_W'(1);
            end
        end
    end

    // Group position register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end

endmodule

// File: rtl/sat_clr_counter.sv
// Saturating event counter that is cleared by a read.
// A clear and an increment in the same cycle leave the counter at one.
module sat_clr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d;

    // Next count: a clear wins over the held value, never over the event.
    always_comb begin
        if (clr) begin
            cnt_d = inc ? CNT_W'(1) : '0;
        end else if (inc && (cnt != CNT_MAX)) begin
            cnt_d = cnt + CNT_W'(1);
        end else begin
            cnt_d = cnt;
        end
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            cnt <= cnt_d;
        end
    end

endmodule

// File: rtl/errstat_rd_port.sv
// Address decode and registered read data for the counter bank.
// Raises a one-cycle clear for the counter being read. Any address
// outside the mapped window returns zero and clears nothing.
module errstat_rd_port #(
    parameter int CNT_W    = 16,
    parameter int ADDR_W   = 5,
    parameter int NUM      = 4,
    parameter int BASE     = 22
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_en,
    input  logic [ADDR_W-1:0]         rd_addr,
    input  logic [NUM-1:0][CNT_W-1:0] cnt_in,
    output logic [NUM-1:0]            clr_vec,
    output logic [CNT_W-1:0]          rd_data
);
    logic [CNT_W-1:0] sel_val;

    // One decoder per counter slot.
    for (genvar k = 0; k < NUM; k++) begin : g_dec
        assign clr_vec[k] = rd_en && (rd_addr == ADDR_W'(BASE + k));
    end

    // One-hot OR mux of the selected count; zero when nothing is hit.
    always_comb begin
        sel_val = '0;
        for (int k = 0; k < NUM; k++) begin
            if (clr_vec[k]) begin
                sel_val = sel_val | cnt_in[k];
            end
        end
    end

    // Read data register, loaded only by a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= sel_val;
        end
    end

endmodule

// File: rtl/phy_errstat_bank.sv
// Bank of four saturating, clear-on-read PHY error counters with a
// management read port. Symbol errors pass through a run grouper first.
// Assumes the event strobes are single-cycle and synchronous to clk.
module phy_errstat_bank
    import phy_errstat_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int ADDR_W    = 5,
    parameter int GROUP_LEN = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sym_valid,
    input  logic              sym_bad,
    input  logic              frame_active,
    input  logic              ev_premature_eof,
    input  logic              ev_eof_err,
    input  logic              ev_jabber,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data
);
    logic                          sym_grp_evt;
    logic [NUM_CNT-1:0]            ev_vec;
    logic [NUM_CNT-1:0]            clr_vec;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;

    sym_run_grouper #(
        .GROUP_LEN (GROUP_LEN)
    ) grouper_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sym_valid    (sym_valid),
        .sym_bad      (sym_bad),
        .frame_active (frame_active),
        .grp_evt      (sym_grp_evt)
    );

    // Route each event source to its counter slot.
    always_comb begin
        ev_vec                 = '0;
        ev_vec[SLOT_SYMBOL]    = sym_grp_evt;
        ev_vec[SLOT_PREMATURE] = ev_premature_eof;
        ev_vec[SLOT_EOF_ERR]   = ev_eof_err;
        ev_vec[SLOT_JABBER]    = ev_jabber;
    end

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
        sat_clr_counter #(
            .CNT_W (CNT_W)
        ) cnt_i (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (ev_vec[k]),
            .clr   (clr_vec[k]),
            .cnt   (cnt_q[k])
        );
    end

    errstat_rd_port #(
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W),
        .NUM    (NUM_CNT),
        .BASE   (REG_BASE)
    ) rd_port_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .cnt_in  (cnt_q),
        .clr_vec (clr_vec),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/phy_errstat_chk.sv
// Property checker for the counter bank, bound to the top module.
// Observes counter state, clears, events and the read port.
module phy_errstat_chk #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 5,
    parameter int NUM    = 4,
    parameter int BASE   = 22
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      rd_en,
    input logic [ADDR_W-1:0]         rd_addr,
    input logic [CNT_W-1:0]          rd_data,
    input logic [NUM-1:0]            ev_vec,
    input logic [NUM-1:0]            clr_vec,
    input logic [NUM-1:0][CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic in_window;
    assign in_window = (rd_addr >= ADDR_W'(BASE)) && (rd_addr < ADDR_W'(BASE + NUM));

    for (genvar k = 0; k < NUM; k++) begin : g_prop
        // R1: a counter moves by at most one per cycle unless cleared
        a_r1_single_step: assert property (@(posedge clk) disable iff (!rst_n)
            !clr_vec[k] |=> (cnt_q[k] == $past(cnt_q[k])) ||
                            (cnt_q[k] == $past(cnt_q[k]) + CNT_W'(1)));

        // R2: full scale holds
        a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q[k] == CNT_MAX) && !clr_vec[k] |=> cnt_q[k] == CNT_MAX);

        // R3 and R6: a read leaves zero, or one if an event coincided
        a_r3_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
            clr_vec[k] |=> cnt_q[k] == CNT_W'($past(ev_vec[k])));

        // R3: read data carries the value from before the clear
        a_r3_read_value: assert property (@(posedge clk) disable iff (!rst_n)
            rd_en && (rd_addr == ADDR_W'(BASE + k)) |=> rd_data == $past(cnt_q[k]));
    end

    // R7: reads outside the window return zero
    a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !in_window |=> rd_data == '0);

    // R7: reads outside the window clear nothing
    a_r7_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !in_window |-> clr_vec == '0);

    // R9: read data holds between reads
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

bind phy_errstat_bank phy_errstat_chk #(
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W),
    .NUM    (phy_errstat_pkg::NUM_CNT),
    .BASE   (phy_errstat_pkg::REG_BASE)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .ev_vec  (ev_vec),
    .clr_vec (clr_vec),
    .cnt_q   (cnt_q)
);

// File: tb/phy_errstat_bank_tb_top.sv
// Directed bench for the PHY error statistics bank.
module phy_errstat_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sym_valid = 1'b0;
    logic        sym_bad = 1'b0;
    logic        frame_active = 1'b0;
    logic        ev_premature_eof = 1'b0;
    logic        ev_eof_err = 1'b0;
    logic        ev_jabber = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  rd_addr = '0;
    logic [15:0] rd_data;

    int n_vec  = 0;
    int n_miss = 0;

    always #5 clk = ~clk;

    phy_errstat_bank dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .sym_valid        (sym_valid),
        .sym_bad          (sym_bad),
        .frame_active     (frame_active),
        .ev_premature_eof (ev_premature_eof),
        .ev_eof_err       (ev_eof_err),
        .ev_jabber        (ev_jabber),
        .rd_en            (rd_en),
        .rd_addr          (rd_addr),
        .rd_data          (rd_data)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_miss++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
        end
    endtask

    task automatic read_reg(input logic [4:0] addr, output logic [15:0] val);
        @(negedge clk);
        rd_en   = 1'b1;
        rd_addr = addr;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        val   = rd_data;
    endtask

    task automatic expect_reg(input string req, input logic [4:0] addr, input logic [15:0] exp);
        logic [15:0] v;
        read_reg(addr, v);
        check(req, v, exp);
    endtask

    task automatic pulse(input int which, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ev_premature_eof = (which == 1);
            ev_eof_err       = (which == 2);
            ev_jabber        = (which == 3);
        end
        @(negedge clk);
        ev_premature_eof = 1'b0;
        ev_eof_err       = 1'b0;
        ev_jabber        = 1'b0;
    endtask

    task automatic symbols(input int n, input logic bad, input logic valid);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sym_valid = valid;
            sym_bad   = bad;
        end
        @(negedge clk);
        sym_valid = 1'b0;
        sym_bad   = 1'b0;
    endtask

    task automatic run_in_frame(input int nbad, input logic [15:0] exp, input string req);
        @(negedge clk);
        frame_active = 1'b1;
        symbols(nbad, 1'b1, 1'b1);
        @(negedge clk);
        frame_active = 1'b0;
        expect_reg(req, 5'd22, exp);
    endtask

    // R8: everything reads zero after reset
    task automatic t_reset();
        for (int a = 22; a <= 25; a++) expect_reg("R8 reset", 5'(a), 16'h0000);
    endtask

    // R1, R3: mapping, one per strobe, clear after read
    task automatic t_mapping();
        pulse(1, 5);
        pulse(2, 3);
        pulse(3, 7);
        expect_reg("R1 symbol idle", 5'd22, 16'd0);
        expect_reg("R1 premature", 5'd23, 16'd5);
        expect_reg("R1 eof err", 5'd24, 16'd3);
        expect_reg("R1 jabber", 5'd25, 16'd7);
        expect_reg("R3 cleared after read", 5'd23, 16'd0);
        expect_reg("R3 cleared after read", 5'd25, 16'd0);
    endtask

    // R4: group counting
    task automatic t_groups();
        run_in_frame(5,  16'd1, "R4 run of 5");
        run_in_frame(6,  16'd1, "R4 run of 6");
        run_in_frame(7,  16'd2, "R4 run of 7");
        run_in_frame(12, 16'd2, "R4 run of 12");
        run_in_frame(13, 16'd3, "R4 run of 13");
    endtask

    // R5: restart and gating
    task automatic t_restart();
        @(negedge clk);
        frame_active = 1'b1;
        symbols(5, 1'b1, 1'b1);
        symbols(1, 1'b0, 1'b1);
        symbols(5, 1'b1, 1'b1);
        @(negedge clk);
        frame_active = 1'b0;
        expect_reg("R5 good symbol restarts", 5'd22, 16'd2);
        @(negedge clk);
        frame_active = 1'b1;
        symbols(3, 1'b1, 1'b1);
        @(negedge clk);
        frame_active = 1'b0;
        @(negedge clk);
        frame_active = 1'b1;
        symbols(3, 1'b1, 1'b1);
        @(negedge clk);
        frame_active = 1'b0;
        expect_reg("R5 frame end restarts", 5'd22, 16'd2);
        symbols(8, 1'b1, 1'b1);
        expect_reg("R5 outside frame ignored", 5'd22, 16'd0);
        @(negedge clk);
        frame_active = 1'b1;
        symbols(3, 1'b1, 1'b1);
        symbols(4, 1'b1, 1'b0);
        symbols(3, 1'b1, 1'b1);
        @(negedge clk);
        frame_active = 1'b0;
        expect_reg("R5 invalid symbols ignored", 5'd22, 16'd1);
    endtask

    // R6: event coincides with a read
    task automatic t_collide();
        logic [15:0] v;
        pulse(3, 2);
        @(negedge clk);
        rd_en     = 1'b1;
        rd_addr   = 5'd25;
        ev_jabber = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_en     = 1'b0;
        ev_jabber = 1'b0;
        v = rd_data;
        check("R6 old value returned", v, 16'd2);
        expect_reg("R6 event kept", 5'd25, 16'd1);
    endtask

    // R2: saturation at full scale
    task automatic t_saturate();
        @(negedge clk);
        ev_eof_err = 1'b1;
        repeat (65540) @(negedge clk);
        ev_eof_err = 1'b0;
        expect_reg("R2 saturates", 5'd24, 16'hFFFF);
        expect_reg("R2 clears after saturation", 5'd24, 16'd0);
    endtask

    // R7, R9: reserved and unmapped reads
    task automatic t_unmapped();
        logic [15:0] v;
        pulse(1, 4);
        expect_reg("R9 load read data", 5'd23, 16'd4);
        pulse(1, 4);
        repeat (3) @(negedge clk);
        check("R9 read data holds", rd_data, 16'd4);
        expect_reg("R7 reserved reads zero", 5'd26, 16'd0);
        expect_reg("R7 unmapped reads zero", 5'd0, 16'd0);
        expect_reg("R7 unmapped reads zero", 5'd31, 16'd0);
        read_reg(5'd21, v);
        check("R7 below window reads zero", v, 16'd0);
        expect_reg("R7 counter untouched", 5'd23, 16'd4);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_miss++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R8 read data in reset", rd_data, 16'd0);
        rst_n = 1'b1;
        t_reset();
        t_mapping();
        t_groups();
        t_restart();
        t_collide();
        t_saturate();
        t_unmapped();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

endmodule